// File: doc/BRIEF.md
# Asynchronous Handshake Bus Master

This block lets a local client run single read and write transfers on a 16-bit strobe bus whose cycle length is set by the slave. The client presents a request: a 23-bit word address, a word or byte size, a choice of upper or lower byte lane, a direction and write data. The block then runs one bus cycle. It presents the address, asserts the address strobe together with the data strobes for the lanes in use, and waits as long as the slave needs. The cycle ends when the slave pulls its acknowledge low.

All bus strobes are active low. The acknowledge arrives without any relation to the local clock, so it passes through a flop synchronizer before the sequencer acts on it. When the synchronized acknowledge is seen, the block captures read data and drops every strobe. It then gives the client a one-cycle completion pulse. After that it refuses new work until the acknowledge has gone high again. The block owns the tristate data bus. It drives the bus only while a write is in progress and releases it at all other times.

Top module: `hsbm_master`

## Requirements
- R1: During and after synchronous reset, the bus strobes (`bus_as_n`, `bus_uds_n`, `bus_lds_n`) are high, `bus_rw` is 1, the data bus is released (all Z), `done` is 0 and `req_ready` is 1 once reset is low.
- R2: The address of an accepted request appears on `bus_addr` one full cycle before `bus_as_n` falls. It stays unchanged for as long as `bus_as_n` is low.
- R3: `bus_rw` is 1 for a read (`req_read`=1) and 0 for a write. It takes that value when the address appears and holds it while `bus_as_n` is low.
- R4: The data strobes are low only in cycles where `bus_as_n` is low. A word transfer (`req_byte`=0) asserts both. A byte transfer asserts `bus_uds_n` alone when `req_upper`=1 (lane bits 15:8) and `bus_lds_n` alone when `req_upper`=0 (lane bits 7:0).
- R5: While `bus_dtack_n` stays high, the strobes remain asserted with no upper limit on the number of wait cycles.
- R6: `bus_dtack_n` passes through a 2-stage synchronizer. If the slave pulls it low during the first strobed cycle, the strobes stay low for exactly 3 cycles. Each extra cycle the slave delays adds one strobed cycle.
- R7: `rdata` is captured on the edge at which the strobes deassert. A word read returns all 16 bus bits. A byte read returns the selected lane in bits 7:0 with bits 15:8 cleared.
- R8: For a write, the block drives the data bus from the address cycle (before the data strobes fall) until the strobes rise. A byte write places `req_wdata[7:0]` on both lanes. At all other times the bus is released.
- R9: After the strobes rise, `req_ready` stays low until the synchronized acknowledge is high again. It returns exactly 3 cycles after the slave releases `bus_dtack_n`, and `bus_as_n` stays high in between.
- R10: `done` is a single-cycle pulse in the cycle right after the strobes rise. A second `done` needs a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on a clock edge when both are high |
| req_addr | input | 23 | Word address |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_upper | input | 1 | Byte lane: 1 = bits 15:8, 0 = bits 7:0 |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with and after `done` |
| bus_addr | output | 23 | Bus word address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_data | inout | 16 | Tristate data bus |
| bus_dtack_n | input | 1 | Slave acknowledge, active low, asynchronous |

## Verification
The assertions assume the slave pulls `bus_dtack_n` low only in reply to an asserted address strobe. They also assume it holds the acknowledge low until it sees the strobes rise, and that it drives the data bus only during a read while it acknowledges. The bench's slave model obeys these rules. It changes its acknowledge and data only on falling clock edges, one full bus cycle at a time, with programmable delays before it acknowledges and before it releases. Requests are offered only while `req_ready` is high.

// File: rtl/hsbm_pkg.sv
package hsbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_STRB  = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic byte_op;
        logic hi;
    } xfer_kind_t;

    // Active-high lane enables {upper, lower}
    function automatic logic [1:0] lane_enables(input xfer_kind_t k);
        if (!k.byte_op)
            return 2'b11;
        return k.hi ? 2'b10 : 2'b01;
    endfunction

    function automatic logic strobes_on(input seq_state_e s);
        return s == ST_STRB;
    endfunction

    function automatic logic cycle_open(input seq_state_e s);
        return (s == ST_ADDR) || (s == ST_STRB);
    endfunction

endpackage

// File: rtl/hsbm_sync.sv
module hsbm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsbm_lanes.sv
module hsbm_lanes #(
    parameter int LANE_W = 8,
    localparam int DW    = 2 * LANE_W
) (
    input  hsbm_pkg::xfer_kind_t wr_kind,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        wr_image,
    input  hsbm_pkg::xfer_kind_t rd_kind,
    input  logic [DW-1:0]        rd_bus,
    output logic [DW-1:0]        rd_word
);
    // Write image: a byte write repeats the low byte on every lane
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign wr_image[g*LANE_W +: LANE_W] =
            wr_kind.byte_op ? wr_data[LANE_W-1:0] : wr_data[g*LANE_W +: LANE_W];
    end

    // Read extract: a byte read is right-justified, upper lane cleared
    always_comb begin
        if (!rd_kind.byte_op)
            rd_word = rd_bus;
        else if (rd_kind.hi)
            rd_word = {{LANE_W{1'b0}}, rd_bus[DW-1:LANE_W]};
        else
            rd_word = {{LANE_W{1'b0}}, rd_bus[LANE_W-1:0]};
    end
endmodule

// File: rtl/hsbm_seq.sv
module hsbm_seq
    import hsbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       ack_s,
    input  xfer_kind_t kind_eff,
    output logic       take,
    output logic       capture,
    output logic       idle,
    output logic       done,
    output logic       as_n,
    output logic       uds_n,
    output logic       lds_n,
    output logic       rw,
    output logic       data_oe
);
    seq_state_e state, nxt;
    logic [1:0] lane_on;

    assign idle    = (state == ST_IDLE);
    assign take    = idle && req_valid;
    assign capture = (state == ST_STRB) && !ack_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_STRB;
            ST_STRB:  if (!ack_s) nxt = ST_RECOV;
            ST_RECOV: if (ack_s)  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign lane_on = strobes_on(nxt) ? lane_enables(kind_eff) : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            as_n    <= 1'b1;
            uds_n   <= 1'b1;
            lds_n   <= 1'b1;
            rw      <= 1'b1;
            data_oe <= 1'b0;
        end else begin
            state   <= nxt;
            done    <= capture;
            as_n    <= !strobes_on(nxt);
            uds_n   <= !lane_on[1];
            lds_n   <= !lane_on[0];
            rw      <= cycle_open(nxt) ? kind_eff.rd : 1'b1;
            data_oe <= cycle_open(nxt) && !kind_eff.rd;
        end
    end
endmodule

// File: rtl/hsbm_master.sv
module hsbm_master
    import hsbm_pkg::*;
#(
    parameter int AW          = 23,
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DW         = 2 * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_byte,
    input  logic          req_upper,
    input  logic          req_read,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_as_n,
    output logic          bus_uds_n,
    output logic          bus_lds_n,
    output logic          bus_rw,
    inout  wire  [DW-1:0] bus_data,
    input  logic          bus_dtack_n
);
    xfer_kind_t    kind_q, kind_req, kind_eff;
    logic          take, capture, ack_s, data_oe;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wimg_q, wimg_d, rword;

    assign kind_req = '{rd: req_read, byte_op: req_byte, hi: req_upper};
    assign kind_eff = take ? kind_req : kind_q;

    hsbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_dtack_n),
        .q   (ack_s)
    );

    hsbm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ack_s     (ack_s),
        .kind_eff  (kind_eff),
        .take      (take),
        .capture   (capture),
        .idle      (req_ready),
        .done      (done),
        .as_n      (bus_as_n),
        .uds_n     (bus_uds_n),
        .lds_n     (bus_lds_n),
        .rw        (bus_rw),
        .data_oe   (data_oe)
    );

    hsbm_lanes #(.LANE_W(LANE_W)) u_lanes (
        .wr_kind  (kind_req),
        .wr_data  (req_wdata),
        .wr_image (wimg_d),
        .rd_kind  (kind_q),
        .rd_bus   (bus_data),
        .rd_word  (rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '{rd: 1'b1, byte_op: 1'b0, hi: 1'b0};
            addr_q <= '0;
            wimg_q <= '0;
            rdata  <= '0;
        end else begin
            if (take) begin
                kind_q <= kind_req;
                addr_q <= req_addr;
                wimg_q <= wimg_d;
            end
            if (capture && kind_q.rd)
                rdata <= rword;
        end
    end

    assign bus_addr = addr_q;
    assign bus_data = data_oe ? wimg_q : {DW{1'bz}};
endmodule

// File: rtl/hsbm_master_chk.sv
module hsbm_master_chk #(
    parameter int AW = 23
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          done,
    input logic [AW-1:0] bus_addr,
    input logic          bus_as_n,
    input logic          bus_uds_n,
    input logic          bus_lds_n,
    input logic          bus_rw,
    input logic          bus_dtack_n
);
    AST_ADDR_LEADS_AS: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_as_n) |-> $stable(bus_addr)) else $error("addr not settled"); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_addr)) else $error("addr moved"); // R2

    AST_RW_HELD: assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |-> $stable(bus_rw)) else $error("rw moved"); // R3

    AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (rst)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n) else $error("ds outside as"); // R4

    AST_DS_PRESENT: assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |-> (!bus_uds_n || !bus_lds_n)) else $error("as without ds"); // R4

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && $past(bus_dtack_n, 2)) |=> !bus_as_n) else $error("early end"); // R5

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_as_n && bus_uds_n && bus_lds_n)) else $error("idle strobe"); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done stretched"); // R10
endmodule

bind hsbm_master hsbm_master_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_hsbm_master.sv
module tb_hsbm_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        req_upper = 1'b0;
    logic        req_read = 1'b1;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic [22:0] bus_addr;
    logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw;
    wire  [15:0] bus_data;
    logic        bus_dtack_n = 1'b1;

    int          total = 0;
    int          bad = 0;
    int          slv_wait = 0;
    int          slv_hold = 0;
    int          wcnt = 0;
    int          hcnt = 0;
    logic [15:0] slv_data = '0;

    always #4 clk = ~clk;

    hsbm_master dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte), .req_upper(req_upper),
        .req_read(req_read), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
        .bus_lds_n(bus_lds_n), .bus_rw(bus_rw), .bus_data(bus_data),
        .bus_dtack_n(bus_dtack_n)
    );

    // Slave model: acts on falling edges only
    assign bus_data = (!bus_as_n && bus_rw && !bus_dtack_n) ? slv_data : 16'hzzzz;

    always @(negedge clk) begin
        if (rst) begin
            bus_dtack_n <= 1'b1; wcnt = 0; hcnt = 0;
        end else if (!bus_as_n) begin
            hcnt = 0;
            if (wcnt >= slv_wait) bus_dtack_n <= 1'b0;
            else wcnt++;
        end else begin
            wcnt = 0;
            if (!bus_dtack_n) begin
                if (hcnt >= slv_hold) begin bus_dtack_n <= 1'b1; hcnt = 0; end
                else hcnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(negedge clk); #1;
    endtask

    task automatic run_xfer(input logic rd, input logic bt, input logic hi,
                            input logic [22:0] addr, input logic [15:0] wd,
                            input logic [15:0] sd, input int w, input int h);
        logic [15:0] img, exp_rd;
        logic [1:0]  ds_exp;
        int          n, g;
        img    = bt ? {wd[7:0], wd[7:0]} : wd;
        exp_rd = !bt ? sd : (hi ? {8'h00, sd[15:8]} : {8'h00, sd[7:0]});
        ds_exp = !bt ? 2'b00 : (hi ? 2'b01 : 2'b10);
        slv_wait = w; slv_hold = h; slv_data = sd;
        n = 0;
        while (!req_ready && n < 200) begin tick(); n++; end
        req_valid = 1'b1; req_addr = addr; req_byte = bt; req_upper = hi;
        req_read = rd; req_wdata = wd;
        tick();
        req_valid = 1'b0; req_addr = ~addr; req_wdata = ~wd;
        // address cycle
        chk("R2 address before strobe", {31'd0, bus_as_n}, 32'd1);
        chk("R2 address value", {9'd0, bus_addr}, {9'd0, addr});
        chk("R3 rw direction", {31'd0, bus_rw}, {31'd0, rd});
        chk("R4 no ds in address cycle", {30'd0, bus_uds_n, bus_lds_n}, 32'd3);
        if (rd) chk("R8 bus released on read", {16'd0, bus_data}, {16'd0, 16'hzzzz});
        else    chk("R8 write data before strobes", {16'd0, bus_data}, {16'd0, img});
        tick();
        n = 0;
        while (!bus_as_n && n < 500) begin
            chk("R4 strobe lanes", {30'd0, bus_uds_n, bus_lds_n}, {30'd0, ds_exp});
            chk("R2 address held", {9'd0, bus_addr}, {9'd0, addr});
            chk("R3 rw held", {31'd0, bus_rw}, {31'd0, rd});
            chk("R10 no early done", {31'd0, done}, 32'd0);
            if (!rd) chk("R8 write data held", {16'd0, bus_data}, {16'd0, img});
            n++; tick();
        end
        chk("R5 R6 strobed cycles", n, w + 3);
        chk("R10 done pulse", {31'd0, done}, 32'd1);
        chk("R4 strobes released", {30'd0, bus_uds_n, bus_lds_n}, 32'd3);
        if (rd) chk("R7 read data", {16'd0, rdata}, {16'd0, exp_rd});
        else    chk("R8 bus released after write", {16'd0, bus_data}, {16'd0, 16'hzzzz});
        tick();
        chk("R10 done single cycle", {31'd0, done}, 32'd0);
        g = 1;
        while (!req_ready && g < 500) begin
            chk("R9 no strobe while recovering", {31'd0, bus_as_n}, 32'd1);
            g++; tick();
        end
        chk("R9 ready gap", g, h + 3);
    endtask

    task automatic test_reset;
        tick();
        chk("R1 as in reset", {31'd0, bus_as_n}, 32'd1);
        chk("R1 ds in reset", {30'd0, bus_uds_n, bus_lds_n}, 32'd3);
        chk("R1 rw in reset", {31'd0, bus_rw}, 32'd1);
        chk("R1 bus released in reset", {16'd0, bus_data}, {16'd0, 16'hzzzz});
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 as after reset", {31'd0, bus_as_n}, 32'd1);
    endtask

    task automatic test_idle_hold;
        // no request: bus must stay quiet (R1)
        repeat (5) tick();
        chk("R1 idle quiet", {29'd0, bus_as_n, bus_uds_n, bus_lds_n}, 32'd7);
        chk("R10 no spontaneous done", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_idle_hold();
        run_xfer(1'b1, 1'b0, 1'b0, 23'h12345, 16'h0000, 16'hBEEF, 0, 0);   // R7 word read
        run_xfer(1'b0, 1'b0, 1'b0, 23'h7FFFFF, 16'hA55A, 16'h0000, 2, 1);  // R8 word write
        run_xfer(1'b1, 1'b1, 1'b1, 23'h000010, 16'h0000, 16'hC3D4, 1, 0);  // R7 upper byte read
        run_xfer(1'b1, 1'b1, 1'b0, 23'h000011, 16'h0000, 16'hC3D4, 0, 2);  // R7 lower byte read
        run_xfer(1'b0, 1'b1, 1'b1, 23'h400000, 16'h9F6E, 16'h0000, 0, 0);  // R8 upper byte write
        run_xfer(1'b0, 1'b1, 1'b0, 23'h2AAAAA, 16'h1234, 16'h0000, 3, 0);  // R8 lower byte write
        run_xfer(1'b1, 1'b0, 1'b0, 23'h000000, 16'h0000, 16'h0F0F, 20, 5); // R5 long wait
        run_xfer(1'b1, 1'b0, 1'b0, 23'h555555, 16'h0000, 16'hFFFF, 0, 0);  // R6 back to back
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule